// File: doc/BRIEF.md
# Two-Stage Immediate-Add Integer Core

This block is a very small integer datapath. It runs one operation: add a sign-extended 12-bit immediate to a register and write the sum to a register. Work is split over two pipeline stages.

The first stage holds the program counter and puts it on a byte-address fetch output. An external instruction memory answers on the instruction input in the same cycle. At each clock edge the returned word is captured into an instruction register, and the counter moves forward by four.

The second stage uses the captured word. It decodes the word, reads the source register, adds the immediate, and writes the destination register at the next edge. Eight architectural registers are visible on debug outputs, so a harness can follow the program's effect.

Because the instruction register clears on reset, the first cycle after reset has no effect. After that, every result appears exactly one clock later than it would in a single-cycle design.

Top module: `addi_pipe_core`

## Requirements
- R1: While reset is held through a clock edge, that edge sets fetch_addr to 0 and sets every debug output to 0.
- R2: After reset is released, fetch_addr rises by exactly 4 at every clock edge. Its two low bits therefore stay 0.
- R3: The instruction register clears on reset. At the first clock edge after reset release, no register changes.
- R4: A word counts as an immediate-add when opcode bits [6:0] are 0010011 and bits [14:12] are 000. For such a word, the destination named by bits [11:7] receives the source named by bits [19:15] plus bits [31:20] sign-extended to 32 bits. The sum wraps modulo 2^32.
- R5: A write aimed at register 0 is discarded, and register 0 always reads as 0.
- R6: Any word that is not an immediate-add leaves every register unchanged. This includes the all-zero word, a word with another bits [14:12] value, and a word with another opcode.
- R7: The word fetched at address 4k changes its destination at clock edge k+2 after reset release. That is one edge later than a single-cycle design.
- R8: Back-to-back dependent words need no stall. A word sees the result of the word fetched just before it. The sequence 0x00500293, 0x00728313, 0x00928413 leaves x5=5, x6=12 and x8=14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr_in | input | 32 | Instruction word held at fetch_addr |
| fetch_addr | output | 32 | Byte address of the word to fetch |
| dbg_x1 | output | 32 | Contents of register 1 |
| dbg_x2 | output | 32 | Contents of register 2 |
| dbg_x5 | output | 32 | Contents of register 5 |
| dbg_x6 | output | 32 | Contents of register 6 |
| dbg_x7 | output | 32 | Contents of register 7 |
| dbg_x8 | output | 32 | Contents of register 8 |
| dbg_x9 | output | 32 | Contents of register 9 |
| dbg_x10 | output | 32 | Contents of register 10 |

## Verification
Two things happen at the same clock edge. The second stage writes back the result of word n, and the first stage captures word n+1. Word n+1 then reads, in the very next cycle, the register that was just written. A word that names one register as both source and destination makes a related collision: it reads the old value and writes the new value in the same cycle.

The directed program provokes both cases: the dependent chain, and repeated increments and decrements of one register. A seeded random stream then mixes immediate-adds over the visible registers with words that must not write. Every register output and the fetch address are compared in every cycle against a reference model in the bench. That model follows the one-edge delay stated in R7.

// File: rtl/addi_core_pkg.sv
`timescale 1ns/1ps
package addi_core_pkg;

    localparam int XLEN   = 32;
    localparam int NREG   = 32;
    localparam int RIDX_W = $clog2(NREG);
    localparam int IMM_W  = 12;

    localparam logic [6:0] OPC_OPIMM = 7'b0010011;
    localparam logic [2:0] F3_ADDI   = 3'b000;

    typedef enum logic {
        ALU_ADD    = 1'b0,
        ALU_PASS_B = 1'b1
    } alu_op_e;

    typedef struct packed {
        logic              wr_en;
        logic [RIDX_W-1:0] rd;
        logic [RIDX_W-1:0] rs1;
        logic [XLEN-1:0]   imm;
        alu_op_e           op;
    } ctrl_t;

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
    endfunction

    function automatic logic is_addi(input logic [31:0] w);
        return (w[6:0] == OPC_OPIMM) && (w[14:12] == F3_ADDI);
    endfunction

endpackage

// File: rtl/fetch_stage.sv
`timescale 1ns/1ps
module fetch_stage
    import addi_core_pkg::*;
#(
    parameter int              STEP     = 4,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [31:0]     instr_i,
    output logic [XLEN-1:0] pc_o,
    output logic [31:0]     ireg_o
);

    logic [XLEN-1:0] pc_q;
    logic [31:0]     ireg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= RESET_PC;
            ireg_q <= '0;
        end else begin
            pc_q   <= pc_q + XLEN'(STEP);
            ireg_q <= instr_i;
        end
    end

    assign pc_o   = pc_q;
    assign ireg_o = ireg_q;

    logic seen_rst;
    always_ff @(posedge clk) begin
        if (rst) seen_rst <= 1'b1;
    end

    // R2: sequential byte-address stepping
    a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
        (seen_rst && !$past(rst)) |-> (pc_q == $past(pc_q) + XLEN'(STEP)));

    // R2: low address bits stay clear
    a_r2_pc_aligned: assert property (@(posedge clk) disable iff (rst)
        seen_rst |-> (pc_q[1:0] == 2'b00));

    // R3: bubble in the first cycle after reset
    a_r3_bubble: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ireg_q == '0));

endmodule

// File: rtl/decode_ctrl.sv
`timescale 1ns/1ps
module decode_ctrl
    import addi_core_pkg::*;
(
    input  logic [31:0] word_i,
    output ctrl_t       ctrl_o
);

    always_comb begin
        ctrl_o.wr_en = is_addi(word_i);
        ctrl_o.rd    = word_i[11:7];
        ctrl_o.rs1   = word_i[19:15];
        ctrl_o.imm   = sext_imm(word_i[31:20]);
        ctrl_o.op    = ALU_ADD;
    end

endmodule

// File: rtl/int_alu.sv
`timescale 1ns/1ps
module int_alu
    import addi_core_pkg::*;
(
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  alu_op_e         op_i,
    output logic [XLEN-1:0] y_o
);

    always_comb begin
        unique case (op_i)
            ALU_ADD:    y_o = a_i + b_i;
            ALU_PASS_B: y_o = b_i;
            default:    y_o = a_i + b_i;
        endcase
    end

endmodule

// File: rtl/reg_bank.sv
`timescale 1ns/1ps
module reg_bank
    import addi_core_pkg::*;
#(
    parameter int NTAP          = 8,
    parameter int TAP_IDX [NTAP] = '{1, 2, 5, 6, 7, 8, 9, 10}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [RIDX_W-1:0] waddr_i,
    input  logic [XLEN-1:0]   wdata_i,
    input  logic [RIDX_W-1:0] raddr_i,
    output logic [XLEN-1:0]   rdata_o,
    output logic [XLEN-1:0]   tap_o [NTAP]
);

    logic [XLEN-1:0] mem [NREG];
    logic            we_eff;

    assign we_eff = we_i && (waddr_i != '0);

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                mem[g] <= '0;
            else if (we_eff && (waddr_i == RIDX_W'(g)))
                mem[g] <= wdata_i;
        end
    end

    assign rdata_o = mem[raddr_i];

    for (genvar t = 0; t < NTAP; t++) begin : g_tap
        assign tap_o[t] = mem[TAP_IDX[t]];
    end

    // R5: register 0 never leaves zero
    a_r5_x0_zero: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (mem[0] == '0));

    // R4: a granted write lands in the addressed register
    a_r4_write_lands: assert property (@(posedge clk) disable iff (rst)
        (we_i && waddr_i != '0) |=> (mem[$past(waddr_i)] == $past(wdata_i)));

endmodule

// File: rtl/addi_pipe_core.sv
`timescale 1ns/1ps
module addi_pipe_core
    import addi_core_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] instr_in,
    output logic [31:0] fetch_addr,
    output logic [31:0] dbg_x1,
    output logic [31:0] dbg_x2,
    output logic [31:0] dbg_x5,
    output logic [31:0] dbg_x6,
    output logic [31:0] dbg_x7,
    output logic [31:0] dbg_x8,
    output logic [31:0] dbg_x9,
    output logic [31:0] dbg_x10
);

    localparam int NTAP = 8;

    logic [31:0]     ireg;
    ctrl_t           ctl;
    logic [XLEN-1:0] rs1_val;
    logic [XLEN-1:0] alu_y;
    logic [XLEN-1:0] taps [NTAP];

    fetch_stage #(.STEP(4), .RESET_PC('0)) u_fetch (
        .clk     (clk),
        .rst     (rst),
        .instr_i (instr_in),
        .pc_o    (fetch_addr),
        .ireg_o  (ireg)
    );

    decode_ctrl u_dec (
        .word_i (ireg),
        .ctrl_o (ctl)
    );

    reg_bank #(.NTAP(NTAP), .TAP_IDX('{1, 2, 5, 6, 7, 8, 9, 10})) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we_i    (ctl.wr_en),
        .waddr_i (ctl.rd),
        .wdata_i (alu_y),
        .raddr_i (ctl.rs1),
        .rdata_o (rs1_val),
        .tap_o   (taps)
    );

    int_alu u_alu (
        .a_i  (rs1_val),
        .b_i  (ctl.imm),
        .op_i (ctl.op),
        .y_o  (alu_y)
    );

    assign dbg_x1  = taps[0];
    assign dbg_x2  = taps[1];
    assign dbg_x5  = taps[2];
    assign dbg_x6  = taps[3];
    assign dbg_x7  = taps[4];
    assign dbg_x8  = taps[5];
    assign dbg_x9  = taps[6];
    assign dbg_x10 = taps[7];

    // R6: a word that is not an immediate-add leaves the visible registers alone
    a_r6_no_write: assert property (@(posedge clk) disable iff (rst)
        ((ireg[6:0] != OPC_OPIMM) || (ireg[14:12] != F3_ADDI)) |=>
        ($stable(dbg_x1) && $stable(dbg_x2) && $stable(dbg_x5) && $stable(dbg_x6) &&
         $stable(dbg_x7) && $stable(dbg_x8) && $stable(dbg_x9) && $stable(dbg_x10)));

    // R4: an immediate-add aimed at register 5 produces source plus immediate
    a_r4_sum_x5: assert property (@(posedge clk) disable iff (rst)
        ((ireg[6:0] == OPC_OPIMM) && (ireg[14:12] == F3_ADDI) && (ireg[11:7] == 5'd5)) |=>
        (dbg_x5 == $past(rs1_val) + $past(sext_imm(ireg[31:20]))));

endmodule

// File: tb/sim_addi_pipe_core.sv
`timescale 1ns/1ps
module sim_addi_pipe_core;

    localparam int ROM_WORDS = 256;
    localparam int NCYC      = 400;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr_in;
    logic [31:0] fetch_addr;
    logic [31:0] dbg_x1, dbg_x2, dbg_x5, dbg_x6, dbg_x7, dbg_x8, dbg_x9, dbg_x10;

    logic [31:0] rom [ROM_WORDS];

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // model state
    logic [31:0] m_reg [32];
    logic [31:0] m_pc;
    logic [31:0] m_ireg;

    always #2 clk = ~clk;

    addi_pipe_core u0 (
        .clk(clk), .rst(rst), .instr_in(instr_in), .fetch_addr(fetch_addr),
        .dbg_x1(dbg_x1), .dbg_x2(dbg_x2), .dbg_x5(dbg_x5), .dbg_x6(dbg_x6),
        .dbg_x7(dbg_x7), .dbg_x8(dbg_x8), .dbg_x9(dbg_x9), .dbg_x10(dbg_x10)
    );

    function automatic logic [31:0] rom_at(input logic [31:0] a);
        logic [13:0] idx;
        idx = a[15:2];
        if (int'(idx) < ROM_WORDS) return rom[idx[7:0]];
        return 32'h0;
    endfunction

    assign instr_in = rom_at(fetch_addr);

    function automatic logic [31:0] enc_addi(input int rd, input int rs1, input logic [11:0] imm);
        return {imm, 5'(rs1), 3'b000, 5'(rd), 7'b0010011};
    endfunction

    function automatic logic [31:0] dut_tap(input int r);
        case (r)
            1:  return dbg_x1;
            2:  return dbg_x2;
            5:  return dbg_x5;
            6:  return dbg_x6;
            7:  return dbg_x7;
            8:  return dbg_x8;
            9:  return dbg_x9;
            10: return dbg_x10;
            default: return 32'hDEAD_BEEF;
        endcase
    endfunction

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // requirement-level reference: one edge of the two-stage machine
    task automatic model_edge();
        logic [31:0] w;
        w = m_ireg;
        if (w[6:0] == 7'b0010011 && w[14:12] == 3'b000 && w[11:7] != 5'd0)
            m_reg[w[11:7]] = m_reg[w[19:15]] + {{20{w[31]}}, w[31:20]};
        m_ireg = rom_at(m_pc);
        m_pc   = m_pc + 32'd4;
    endtask

    task automatic compare_all(input int cyc);
        int vis [8] = '{1, 2, 5, 6, 7, 8, 9, 10};
        check32($sformatf("R2 fetch_addr cyc %0d", cyc), fetch_addr, m_pc);
        foreach (vis[i])
            check32($sformatf("R4 x%0d cyc %0d", vis[i], cyc), dut_tap(vis[i]), m_reg[vis[i]]);
    endtask

    initial begin
        int pool [9] = '{0, 1, 2, 5, 6, 7, 8, 9, 10};
        void'($urandom(32'd20241106));
        for (int i = 0; i < ROM_WORDS; i++) rom[i] = 32'h0;
        rom[0]  = 32'h00500293;                              // x5 = 0 + 5
        rom[1]  = 32'h00728313;                              // x6 = x5 + 7
        rom[2]  = 32'h00928413;                              // x8 = x5 + 9
        rom[3]  = enc_addi(0, 5, 12'd3);                     // write to x0
        rom[4]  = enc_addi(1, 0, 12'd33);                    // x1 = x0 + 33
        rom[5]  = 32'h0000_0000;                             // all-zero word
        rom[6]  = enc_addi(7, 7, 12'hFFF);                   // x7 = x7 - 1
        rom[7]  = {12'h003, 5'd9, 3'b001, 5'd9, 7'b0010011}; // other funct3
        rom[8]  = {7'b0, 5'd6, 5'd5, 3'b000, 5'd10, 7'b0110011}; // other opcode
        rom[9]  = enc_addi(10, 10, 12'h800);                 // x10 = -2048
        rom[10] = enc_addi(7, 7, 12'h001);                   // x7 wraps to 0
        for (int i = 11; i < ROM_WORDS; i++) begin
            int rd  = pool[$urandom_range(8, 0)];
            int rs1 = pool[$urandom_range(8, 0)];
            logic [11:0] imm = 12'($urandom);
            if ($urandom_range(7, 0) == 0)
                rom[i] = {imm, 5'(rs1), 3'($urandom_range(7, 1)), 5'(rd), 7'b0010011};
            else
                rom[i] = enc_addi(rd, rs1, imm);
        end

        for (int i = 0; i < 32; i++) m_reg[i] = 32'h0;
        m_pc = 32'h0;
        m_ireg = 32'h0;

        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check32("R1 fetch_addr", fetch_addr, 32'h0);
        check32("R1 x1", dbg_x1, 32'h0);
        check32("R1 x5", dbg_x5, 32'h0);
        check32("R1 x10", dbg_x10, 32'h0);
        rst = 1'b0;

        for (int n = 1; n <= NCYC; n++) begin
            @(posedge clk);
            model_edge();
            @(negedge clk);
            compare_all(n);
            case (n)
                1: begin
                    check32("R3 no write at first edge x5", dbg_x5, 32'h0);
                    check32("R7 x5 not yet written", dbg_x5, 32'h0);
                    check32("R2 fetch_addr after one edge", fetch_addr, 32'h4);
                end
                2: check32("R7 x5 at edge 2", dbg_x5, 32'd5);
                3: check32("R8 x6 sees x5", dbg_x6, 32'd12);
                4: check32("R8 x8 sees x5", dbg_x8, 32'd14);
                6: check32("R5 x0 reads zero", dbg_x1, 32'd33);
                7: check32("R6 all-zero word x5", dbg_x5, 32'd5);
                8: check32("R4 sign-extended -1", dbg_x7, 32'hFFFF_FFFF);
                9: check32("R6 funct3 001 ignored", dbg_x9, 32'h0);
                10: check32("R6 other opcode ignored", dbg_x10, 32'h0);
                11: check32("R4 imm -2048", dbg_x10, 32'hFFFF_F800);
                12: check32("R4 wrap to zero", dbg_x7, 32'h0);
                default: ;
            endcase
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule